// File: doc/BRIEF.md
# Power-Management Event Controller

This block gathers power-management events from around the chip, records each one in a sticky status flag, and raises one level-sensitive System Control Interrupt (SCI) toward the processor. It watches five sources: the top bit of a free-running timer, a real-time-clock alarm line, an active-low power-button pin, a bus-master request, and a release strobe that firmware pulses when it hands back the global lock.

Software reaches three 16-bit registers through a plain register port: event flags at offset 8h, per-event interrupt masks at Ah and a control word at Ch. Bit 0 of the control word is the interrupt master switch. Bit 1 is a second switch that applies only to bus-master events. Software acknowledges a flag by writing a 1 to it. The SCI stays high while any flag that is enabled remains set.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset the flag, mask and control registers read 0000h and `sci` is low.
- R2: Timer flag (bit 0) is set one clock after `tmr_msb` changes level, in either direction.
- R3: Bus-master flag (bit 4) is set one clock after a cycle with `bm_req` high.
- R4: Power-button flag (bit 8) is set when `pwrbtn_n` falls while `working` is high. A fall while `working` is low leaves it clear.
- R5: RTC flag (bit 10) is set on a rising edge of `rtc_alarm`. While the line stays high the flag is not set again. Global-lock flag (bit 5) is set one clock after a cycle with `gl_release` high.
- R6: Writing 1 to a flag bit at offset 8h clears it. Writing 0 leaves it unchanged.
- R7: If an event and a write-1 clear hit the same flag in the same cycle, the flag stays set.
- R8: Only mask bits 0, 5, 8 and 10 at offset Ah and control bits 0 and 1 at offset Ch can be written. All other bits of these registers, and flag bits other than 0, 4, 5, 8 and 10, read as 0.
- R9: `sci` is high exactly when control bit 0 is 1 and some flag among bits 0, 5, 8 and 10 is set with its matching mask bit set.
- R10: A bus-master flag drives `sci` only when control bits 1 and 0 are both 1.
- R11: Offsets other than 8h, Ah and Ch read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| tmr_msb | input | 1 | Top bit of the free-running timer |
| rtc_alarm | input | 1 | Real-time-clock alarm level |
| pwrbtn_n | input | 1 | Power-button pin, active low |
| working | input | 1 | High while the system is in the Working state |
| bm_req | input | 1 | Bus-master request |
| gl_release | input | 1 | Firmware global-lock release strobe |
| sci | output | 1 | System Control Interrupt, active-high level |

## Verification
A write-1 acknowledge of a flag and a new event on the same flag can fall into the same clock edge. The bench provokes this by raising `bm_req` in the very cycle that software writes 0010h to offset 8h. The flag must then read as set afterwards. A second check repeats the write with no event present and expects the flag to be clear, which shows that the clear path works on its own.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 4;

    localparam int B_TMR = 0;
    localparam int B_BM  = 4;
    localparam int B_GL  = 5;
    localparam int B_PWR = 8;
    localparam int B_RTC = 10;
    localparam int B_SCI_ON = 0;
    localparam int B_BM_ON  = 1;

    localparam logic [ADDR_W-1:0] OFS_FLAG = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_MASK = 4'hA;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'hC;

    localparam logic [REG_W-1:0] MASK_BITS = REG_W'((1 << B_TMR) | (1 << B_GL) | (1 << B_PWR) | (1 << B_RTC));
    localparam logic [REG_W-1:0] FLAG_BITS = MASK_BITS | REG_W'(1 << B_BM);
    localparam logic [REG_W-1:0] CTRL_BITS = REG_W'((1 << B_SCI_ON) | (1 << B_BM_ON));

    typedef struct packed {
        logic tmr;
        logic bm;
        logic gl;
        logic pwr;
        logic rtc;
    } evt_t;
endpackage

// File: rtl/pm_edge_detect.sv
module pm_edge_detect
    import pm_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tmr_msb,
    input  logic rtc_alarm,
    input  logic pwrbtn_n,
    input  logic working,
    input  logic bm_req,
    input  logic gl_release,
    output evt_t evt
);
    typedef struct packed {
        logic armed;
        logic tmr;
        logic rtc;
        logic pwr_n;
    } hist_t;

    hist_t h_d, h_q;

    always_comb begin
        h_d.armed = 1'b1;
        h_d.tmr   = tmr_msb;
        h_d.rtc   = rtc_alarm;
        h_d.pwr_n = pwrbtn_n;

        evt.tmr = h_q.armed & (tmr_msb ^ h_q.tmr);
        evt.rtc = h_q.armed & rtc_alarm & ~h_q.rtc;
        evt.pwr = h_q.armed & working & h_q.pwr_n & ~pwrbtn_n;
        evt.bm  = bm_req;
        evt.gl  = gl_release;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '{armed: 1'b0, tmr: 1'b0, rtc: 1'b0, pwr_n: 1'b1};
        end else begin
            h_q <= h_d;
        end
    end
endmodule

// File: rtl/pm_flag_bank.sv
module pm_flag_bank
    import pm_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  evt_t             evt,
    input  logic [REG_W-1:0] clr,
    output logic [REG_W-1:0] flags
);
    logic [REG_W-1:0] set_v;
    logic [REG_W-1:0] flag_d, flag_q;

    always_comb begin
        set_v        = '0;
        set_v[B_TMR] = evt.tmr;
        set_v[B_BM]  = evt.bm;
        set_v[B_GL]  = evt.gl;
        set_v[B_PWR] = evt.pwr;
        set_v[B_RTC] = evt.rtc;
        flag_d = ((flag_q & ~clr) | set_v) & FLAG_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags = flag_q;
endmodule

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import pm_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  mask,
    output logic [REG_W-1:0]  ctrl
);
    typedef struct packed {
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] ctrl;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (reg_wr && reg_addr == OFS_MASK) c_d.mask = reg_wdata & MASK_BITS;
        if (reg_wr && reg_addr == OFS_CTRL) c_d.ctrl = reg_wdata & CTRL_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign mask = c_q.mask;
    assign ctrl = c_q.ctrl;
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
    import pm_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              tmr_msb,
    input  logic              rtc_alarm,
    input  logic              pwrbtn_n,
    input  logic              working,
    input  logic              bm_req,
    input  logic              gl_release,
    output logic              sci
);
    evt_t             evt;
    logic [REG_W-1:0] clr;
    logic [REG_W-1:0] flag_q;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] gate;

    pm_edge_detect u_edge (
        .clk(clk), .rst_n(rst_n),
        .tmr_msb(tmr_msb), .rtc_alarm(rtc_alarm), .pwrbtn_n(pwrbtn_n),
        .working(working), .bm_req(bm_req), .gl_release(gl_release),
        .evt(evt)
    );

    assign clr = (reg_wr && reg_addr == OFS_FLAG) ? reg_wdata : '0;

    pm_flag_bank u_flags (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr), .flags(flag_q)
    );

    pm_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mask(mask_q), .ctrl(ctrl_q)
    );

    always_comb begin
        case (reg_addr)
            OFS_FLAG: reg_rdata = flag_q;
            OFS_MASK: reg_rdata = mask_q;
            OFS_CTRL: reg_rdata = ctrl_q;
            default:  reg_rdata = '0;
        endcase
    end

    always_comb begin
        gate       = mask_q;
        gate[B_BM] = ctrl_q[B_BM_ON];
        sci        = ctrl_q[B_SCI_ON] & |(flag_q & gate);
    end
endmodule

module pm_event_ctrl_chk
    import pm_evt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              bm_req,
    input logic              gl_release,
    input logic [REG_W-1:0]  flags,
    input logic [REG_W-1:0]  mask,
    input logic [REG_W-1:0]  ctrl,
    input logic              sci
);
    // R3
    bm_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bm_req |=> flags[B_BM]);
    // R5
    gl_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gl_release |=> flags[B_GL]);
    // R6
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_FLAG && reg_wdata[B_BM] && !bm_req) |=> !flags[B_BM]);
    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask & ~MASK_BITS) == '0) && ((ctrl & ~CTRL_BITS) == '0) && ((flags & ~FLAG_BITS) == '0));
    // R9
    sci_master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[B_SCI_ON] |-> !sci);
    // R9
    sci_timer_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[B_SCI_ON] && flags[B_TMR] && mask[B_TMR]) |-> sci);
    // R10
    sci_bm_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[B_SCI_ON] && ctrl[B_BM_ON] && flags[B_BM]) |-> sci);
endmodule

bind pm_event_ctrl pm_event_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bm_req(bm_req), .gl_release(gl_release),
    .flags(flag_q), .mask(mask_q), .ctrl(ctrl_q), .sci(sci)
);

// File: tb/pm_event_ctrl_tb.sv
module pm_event_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        tmr_msb = 1'b0, rtc_alarm = 1'b0, pwrbtn_n = 1'b1, working = 1'b0;
    logic        bm_req = 1'b0, gl_release = 1'b0;
    logic        sci;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_event_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_msb(tmr_msb),
        .rtc_alarm(rtc_alarm), .pwrbtn_n(pwrbtn_n), .working(working),
        .bm_req(bm_req), .gl_release(gl_release), .sci(sci)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(4'h8, v); check("R1 flags", v, 16'h0000);
        rd(4'hA, v); check("R1 mask", v, 16'h0000);
        rd(4'hC, v); check("R1 ctrl", v, 16'h0000);
        check("R1 sci", {15'b0, sci}, 16'h0000);
    endtask

    task automatic t_timer;
        logic [15:0] v;
        @(negedge clk); tmr_msb = 1'b1;
        rd(4'h8, v); check("R2 rise", v, 16'h0001);
        wr(4'h8, 16'h0000);
        rd(4'h8, v); check("R6 write0 keeps", v, 16'h0001);
        wr(4'h8, 16'h0001);
        rd(4'h8, v); check("R6 write1 clears", v, 16'h0000);
        @(negedge clk); tmr_msb = 1'b0;
        rd(4'h8, v); check("R2 fall", v, 16'h0001);
        wr(4'h8, 16'h0001);
    endtask

    task automatic t_busmaster;
        logic [15:0] v;
        @(negedge clk); bm_req = 1'b1;
        @(negedge clk); bm_req = 1'b0;
        rd(4'h8, v); check("R3 bm flag", v, 16'h0010);
        wr(4'hC, 16'h0001);
        #1 check("R10 bm needs bit1", {15'b0, sci}, 16'h0000);
        wr(4'hC, 16'h0003);
        #1 check("R10 bm both bits", {15'b0, sci}, 16'h0001);
        wr(4'hC, 16'h0002);
        #1 check("R10 bm needs bit0", {15'b0, sci}, 16'h0000);
        wr(4'h8, 16'h0010);
        wr(4'hC, 16'h0000);
    endtask

    task automatic t_power;
        logic [15:0] v;
        working = 1'b0;
        @(negedge clk); pwrbtn_n = 1'b0;
        rd(4'h8, v); check("R4 not working", v, 16'h0000);
        @(negedge clk); pwrbtn_n = 1'b1; working = 1'b1;
        @(negedge clk); pwrbtn_n = 1'b0;
        rd(4'h8, v); check("R4 working fall", v, 16'h0100);
        wr(4'h8, 16'h0100);
        @(negedge clk); pwrbtn_n = 1'b1;
    endtask

    task automatic t_rtc_gl;
        logic [15:0] v;
        @(negedge clk); rtc_alarm = 1'b1;
        rd(4'h8, v); check("R5 rtc edge", v, 16'h0400);
        wr(4'h8, 16'h0400);
        rd(4'h8, v); check("R5 rtc held no reset", v, 16'h0000);
        @(negedge clk); rtc_alarm = 1'b0;
        @(negedge clk); gl_release = 1'b1;
        @(negedge clk); gl_release = 1'b0;
        rd(4'h8, v); check("R5 global lock", v, 16'h0020);
    endtask

    task automatic t_sci;
        logic [15:0] v;
        wr(4'hA, 16'h0020);
        #1 check("R9 master off", {15'b0, sci}, 16'h0000);
        wr(4'hC, 16'h0001);
        #1 check("R9 enabled flag", {15'b0, sci}, 16'h0001);
        wr(4'hA, 16'h0401);
        #1 check("R9 flag masked", {15'b0, sci}, 16'h0000);
        wr(4'hA, 16'h0020);
        wr(4'h8, 16'h0020);
        #1 check("R9 after clear", {15'b0, sci}, 16'h0000);
        wr(4'hC, 16'h0000);
        wr(4'hA, 16'h0000);
        rd(4'h8, v); check("R6 all clear", v, 16'h0000);
    endtask

    task automatic t_reserved;
        logic [15:0] v;
        wr(4'hA, 16'hFFFF);
        rd(4'hA, v); check("R8 mask bits", v, 16'h0521);
        wr(4'hC, 16'hFFFF);
        rd(4'hC, v); check("R8 ctrl bits", v, 16'h0003);
        wr(4'h8, 16'hFFFF);
        rd(4'h8, v); check("R8 flag bits", v, 16'h0000);
        wr(4'h0, 16'hFFFF);
        rd(4'h0, v); check("R11 unmapped read", v, 16'h0000);
        rd(4'hA, v); check("R11 mask untouched", v, 16'h0521);
        wr(4'hA, 16'h0000);
        wr(4'hC, 16'h0000);
    endtask

    task automatic t_collide;
        logic [15:0] v;
        @(negedge clk); bm_req = 1'b1;
        @(negedge clk); bm_req = 1'b0;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 16'h0010; bm_req = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; bm_req = 1'b0;
        rd(4'h8, v); check("R7 event wins", v, 16'h0010);
        wr(4'h8, 16'h0010);
        rd(4'h8, v); check("R7 clear alone", v, 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_timer();
        t_busmaster();
        t_power();
        t_rtc_gl();
        t_sci();
        t_reserved();
        t_collide();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule